// File: doc/BRIEF.md
# Shift-Add Two-Pole Low-Pass Filter

This block is a second-order low-pass filter for a small synthesizer voice. It keeps two signed state registers, a band state and a low state. Each audio sample is processed as a fixed run of six one-clock micro-steps. No step uses a multiplier. Every step takes one operand, shifts it right arithmetically by an amount derived from a period word, and adds the result to (or subtracts it from) one of the states. A single shifter and a single saturating adder serve all steps.

Three 9-bit period words set the behaviour. The cutoff period sets the integration rate between the two states. The damping period sets how fast the band state decays, which controls resonance. The volume period sets how strongly the oscillator inputs are fed in. Each period word is a small float: the octave field gives a base shift, and the mantissa makes the shift one larger on some samples, so the average gain falls smoothly across the octave. Each of the two oscillator inputs has an order bit. The bit chooses whether that input goes through both integrators or only the last one.

Top module: `shiftAddFilter`

## Requirements
- R1: While `rst_n` is low, both states, `filtOut` and `outStrobe` are zero. The sample index also resets to zero.
- R2: After reset the block runs six micro-steps repeatedly, one per clock, in this order: feed osc1, feed osc2, damp, integrate, feed back, output. An input is extended to state width by appending (ST_W-IN_W) zero bits below it. With S=saturate, the steps are:
  - feed: `dst = S(dst + in>>>sV)`
  - damp: `band = S(band - band>>>sD)`
  - integrate: `low = S(low + band>>>sC)`
  - feed back: `band = S(band - low>>>sC)`
  - output: `filtOut = low`
- R3: A period word is {octave[8:5], mantissa[4:0]}. Its shift for the sample with index n is octave+1 when bitreverse5(n) < mantissa, and octave otherwise. The index n counts samples modulo 32.
- R4: For the osc1 feed, orderSel bit 0 selects the destination: 1 feeds the band state (second order), 0 feeds the low state (first order). orderSel bit 1 does the same for the osc2 feed.
- R5: Every state update saturates to the signed range of ST_W bits instead of wrapping.
- R6: The damping step takes its shift from `dampPeriod`. A damping shift of 0 clears the band state every sample.
- R7: Both feed steps take their shift from `volPeriod`. A large volume shift makes an input contribute nothing.
- R8: `filtOut` changes only on the clock edge that completes the output step. `outStrobe` is high for exactly the one cycle after that edge, once every six clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc1Sample | input | IN_W | First oscillator sample, signed |
| osc2Sample | input | IN_W | Second oscillator sample, signed |
| cutoffPeriod | input | 9 | Cutoff period word {octave, mantissa} |
| dampPeriod | input | 9 | Damping period word |
| volPeriod | input | 9 | Input volume period word |
| orderSel | input | 2 | Per-input order select (1 = second order) |
| filtOut | output | ST_W | Filtered output (low state), signed |
| outStrobe | output | 1 | One-cycle pulse when filtOut has been updated |

## Verification
The bench drives full-scale inputs of both signs toward the rails. A design that wraps would flip the output to the opposite extreme, where the expected value is pinned at +32767 or -32768. A mantissa of 31 on the volume period must give exactly 31 half-gain samples out of 32. A wrong bit reversal or an off-by-one compare changes the sum after 32 samples. A damping shift of zero must hold the output at zero, which exposes a swapped period selection or a mis-routed order bit. Outputs are also compared sample by sample against a step model, and a mid-sample probe checks that the output never moves between strobes.

// File: rtl/sapFilterPkg.sv
package sapFilterPkg;

  localparam int SH_W = 5;

  typedef enum logic [2:0] {
    STEP_FEED1 = 3'd0,
    STEP_FEED2 = 3'd1,
    STEP_DAMP  = 3'd2,
    STEP_INTEG = 3'd3,
    STEP_FBACK = 3'd4,
    STEP_OUT   = 3'd5
  } stepT;

  typedef enum logic [1:0] {
    SRC_IN1  = 2'd0,
    SRC_IN2  = 2'd1,
    SRC_BAND = 2'd2,
    SRC_LOW  = 2'd3
  } srcT;

  // strobes from control to datapath for one micro-step
  typedef struct packed {
    logic            bandWr;
    logic            lowWr;
    logic            outLoad;
    logic            subtract;
    srcT             addSrc;
    logic [SH_W-1:0] shiftAmt;
  } strobeT;

endpackage

// File: rtl/periodShift.sv
module periodShift #(
  parameter int OCT_W  = 4,
  parameter int MANT_W = 5,
  parameter int SH_W   = 5
) (
  input  logic [OCT_W+MANT_W-1:0] period,
  input  logic [MANT_W-1:0]       phase,
  output logic [SH_W-1:0]         shiftAmt
);
  logic [OCT_W-1:0]  octave;
  logic [MANT_W-1:0] mant;
  logic [MANT_W-1:0] phaseRev;
  logic              extra;

  assign octave = period[OCT_W+MANT_W-1:MANT_W];
  assign mant   = period[MANT_W-1:0];

  // reversed phase spreads the longer shifts evenly over the samples
  always_comb begin
    for (int i = 0; i < MANT_W; i++) begin
      phaseRev[i] = phase[MANT_W-1-i];
    end
  end

  assign extra    = (phaseRev < mant);
  assign shiftAmt = SH_W'(octave) + SH_W'(extra);

endmodule

// File: rtl/filterCtl.sv
module filterCtl
  import sapFilterPkg::*;
#(
  parameter int OCT_W  = 4,
  parameter int MANT_W = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [OCT_W+MANT_W-1:0] cutoffPeriod,
  input  logic [OCT_W+MANT_W-1:0] dampPeriod,
  input  logic [OCT_W+MANT_W-1:0] volPeriod,
  input  logic [1:0]              orderSel,
  output strobeT                  strb
);
  localparam int PW     = OCT_W + MANT_W;
  localparam int N_PER  = 3;
  localparam int MAX_SH = (1 << OCT_W);

  stepT              stepQ;
  logic [MANT_W-1:0] sampleIdx;
  logic [PW-1:0]     periodArr [N_PER];
  logic [SH_W-1:0]   shiftArr  [N_PER];

  assign periodArr[0] = cutoffPeriod;
  assign periodArr[1] = dampPeriod;
  assign periodArr[2] = volPeriod;

  for (genvar g = 0; g < N_PER; g++) begin : gPer
    periodShift #(.OCT_W(OCT_W), .MANT_W(MANT_W), .SH_W(SH_W)) uShift (
      .period  (periodArr[g]),
      .phase   (sampleIdx),
      .shiftAmt(shiftArr[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stepQ     <= STEP_FEED1;
      sampleIdx <= '0;
    end else if (stepQ == STEP_OUT) begin
      stepQ     <= STEP_FEED1;
      sampleIdx <= sampleIdx + 1'b1;
    end else begin
      stepQ <= stepT'(stepQ + 3'd1);
    end
  end

  always_comb begin
    strb = '0;
    strb.addSrc = SRC_BAND;
    case (stepQ)
      STEP_FEED1: begin
        strb.addSrc   = SRC_IN1;
        strb.shiftAmt = shiftArr[2];
        strb.bandWr   = orderSel[0];
        strb.lowWr    = !orderSel[0];
      end
      STEP_FEED2: begin
        strb.addSrc   = SRC_IN2;
        strb.shiftAmt = shiftArr[2];
        strb.bandWr   = orderSel[1];
        strb.lowWr    = !orderSel[1];
      end
      STEP_DAMP: begin
        strb.addSrc   = SRC_BAND;
        strb.shiftAmt = shiftArr[1];
        strb.bandWr   = 1'b1;
        strb.subtract = 1'b1;
      end
      STEP_INTEG: begin
        strb.addSrc   = SRC_BAND;
        strb.shiftAmt = shiftArr[0];
        strb.lowWr    = 1'b1;
      end
      STEP_FBACK: begin
        strb.addSrc   = SRC_LOW;
        strb.shiftAmt = shiftArr[0];
        strb.bandWr   = 1'b1;
        strb.subtract = 1'b1;
      end
      STEP_OUT: strb.outLoad = 1'b1;
      default: strb = '0;
    endcase
  end

  p_step_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stepQ <= STEP_OUT);

  p_one_action_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.bandWr, strb.lowWr, strb.outLoad}));

  p_idx_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stepQ == STEP_OUT) |=> (sampleIdx == $past(sampleIdx) + 1'b1));

  p_shift_bounds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(strb.shiftAmt) <= MAX_SH);

endmodule

// File: rtl/filterPath.sv
module filterPath
  import sapFilterPkg::*;
#(
  parameter int IN_W = 8,
  parameter int ST_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic signed [IN_W-1:0] osc1,
  input  logic signed [IN_W-1:0] osc2,
  input  strobeT                 strb,
  output logic signed [ST_W-1:0] outQ,
  output logic                   outStrobe
);
  localparam int PAD = ST_W - IN_W;
  localparam logic signed [ST_W-1:0] ST_MAX = {1'b0, {(ST_W-1){1'b1}}};
  localparam logic signed [ST_W-1:0] ST_MIN = {1'b1, {(ST_W-1){1'b0}}};

  logic signed [ST_W-1:0] bandQ, lowQ;
  logic signed [ST_W-1:0] addend, shifted, baseVal, nextVal;
  logic signed [ST_W:0]   sumWide;
  logic                   wrEn;

  always_comb begin
    case (strb.addSrc)
      SRC_IN1:  addend = {osc1, {PAD{1'b0}}};
      SRC_IN2:  addend = {osc2, {PAD{1'b0}}};
      SRC_BAND: addend = bandQ;
      default:  addend = lowQ;
    endcase
  end

  // the one shared shifter and adder
  assign shifted = addend >>> strb.shiftAmt;
  assign baseVal = strb.lowWr ? lowQ : bandQ;
  assign wrEn    = strb.bandWr || strb.lowWr;

  always_comb begin
    if (strb.subtract) sumWide = {baseVal[ST_W-1], baseVal} - {shifted[ST_W-1], shifted};
    else               sumWide = {baseVal[ST_W-1], baseVal} + {shifted[ST_W-1], shifted};
    if (sumWide[ST_W] != sumWide[ST_W-1]) nextVal = sumWide[ST_W] ? ST_MIN : ST_MAX;
    else                                  nextVal = sumWide[ST_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bandQ     <= '0;
      lowQ      <= '0;
      outQ      <= '0;
      outStrobe <= 1'b0;
    end else begin
      if (strb.bandWr) bandQ <= nextVal;
      if (strb.lowWr)  lowQ  <= nextVal;
      if (strb.outLoad) outQ <= lowQ;
      outStrobe <= strb.outLoad;
    end
  end

  p_no_wrap_pos_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && !strb.subtract && !baseVal[ST_W-1] && !shifted[ST_W-1]) |-> !nextVal[ST_W-1]);

  p_no_wrap_neg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && !strb.subtract && baseVal[ST_W-1] && shifted[ST_W-1]) |-> nextVal[ST_W-1]);

  p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.outLoad |=> $stable(outQ));

endmodule

// File: rtl/shiftAddFilter.sv
module shiftAddFilter
  import sapFilterPkg::*;
#(
  parameter int IN_W   = 8,
  parameter int ST_W   = 16,
  parameter int OCT_W  = 4,
  parameter int MANT_W = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic signed [IN_W-1:0]    osc1Sample,
  input  logic signed [IN_W-1:0]    osc2Sample,
  input  logic [OCT_W+MANT_W-1:0]   cutoffPeriod,
  input  logic [OCT_W+MANT_W-1:0]   dampPeriod,
  input  logic [OCT_W+MANT_W-1:0]   volPeriod,
  input  logic [1:0]                orderSel,
  output logic signed [ST_W-1:0]    filtOut,
  output logic                      outStrobe
);
  strobeT strb;

  filterCtl #(.OCT_W(OCT_W), .MANT_W(MANT_W)) uCtl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cutoffPeriod(cutoffPeriod),
    .dampPeriod  (dampPeriod),
    .volPeriod   (volPeriod),
    .orderSel    (orderSel),
    .strb        (strb)
  );

  filterPath #(.IN_W(IN_W), .ST_W(ST_W)) uPath (
    .clk      (clk),
    .rst_n    (rst_n),
    .osc1     (osc1Sample),
    .osc2     (osc2Sample),
    .strb     (strb),
    .outQ     (filtOut),
    .outStrobe(outStrobe)
  );

endmodule

// File: tb/shiftAddFilter_test.sv
`timescale 1ns/100ps
module shiftAddFilter_test;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic signed [7:0] osc1 = '0, osc2 = '0;
  logic [8:0]        cutP = '1, dampP = '1, volP = '1;
  logic [1:0]        order = '0;
  logic signed [15:0] filtOut;
  logic              outStrobe;

  int total = 0, bad = 0;
  bit finished = 0;

  // reference state
  int mBand, mLow, mOut, mIdx;

  always #2.5 clk = ~clk;

  shiftAddFilter uut (
    .clk(clk), .rst_n(rst_n),
    .osc1Sample(osc1), .osc2Sample(osc2),
    .cutoffPeriod(cutP), .dampPeriod(dampP), .volPeriod(volP),
    .orderSel(order), .filtOut(filtOut), .outStrobe(outStrobe)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int shiftOf(input logic [8:0] p, input int idx);
    int rev = 0;
    for (int i = 0; i < 5; i++) if (idx[i]) rev |= (1 << (4 - i));
    return int'(p[8:5]) + ((rev < int'(p[4:0])) ? 1 : 0);
  endfunction

  // one sample of the six micro-steps (R2, R3, R4, R6, R7)
  task automatic modelSample();
    int sV = shiftOf(volP, mIdx);
    int sD = shiftOf(dampP, mIdx);
    int sC = shiftOf(cutP, mIdx);
    int in1 = int'(osc1) * 256;
    int in2 = int'(osc2) * 256;
    if (order[0]) mBand = sat(mBand + (in1 >>> sV)); else mLow = sat(mLow + (in1 >>> sV));
    if (order[1]) mBand = sat(mBand + (in2 >>> sV)); else mLow = sat(mLow + (in2 >>> sV));
    mBand = sat(mBand - (mBand >>> sD));
    mLow  = sat(mLow + (mBand >>> sC));
    mBand = sat(mBand - (mLow >>> sC));
    mOut  = mLow;
    mIdx  = (mIdx + 1) % 32;
  endtask

  task automatic applyReset();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    check("R1 out in reset", int'(filtOut), 0);
    check("R1 strobe in reset", int'(outStrobe), 0);
    rst_n = 1'b1;
    mBand = 0; mLow = 0; mOut = 0; mIdx = 0;
  endtask

  // advance one sample, checking hold mid-sample and update at the end
  task automatic runSample(input string req);
    repeat (3) @(posedge clk);
    #1;
    check("R8 hold mid-sample", int'(filtOut), mOut);
    check("R8 no strobe mid-sample", int'(outStrobe), 0);
    repeat (3) @(posedge clk);
    #1;
    modelSample();
    check(req, int'(filtOut), mOut);
    check("R8 strobe at update", int'(outStrobe), 1);
  endtask

  task automatic testReset();
    applyReset();
    check("R1 out after release", int'(filtOut), 0);
  endtask

  task automatic testSecondOrder();
    osc1 = 8'sd40; osc2 = -8'sd20; order = 2'b11;
    cutP = {4'd2, 5'd5}; dampP = {4'd3, 5'd10}; volP = {4'd1, 5'd20};
    applyReset();
    for (int s = 0; s < 40; s++) runSample("R2 R4 second-order response");
    osc1 = -8'sd90;
    for (int s = 0; s < 20; s++) runSample("R2 step change");
  endtask

  task automatic testMixedOrder();
    osc1 = 8'sd60; osc2 = 8'sd30; order = 2'b01;
    cutP = {4'd1, 5'd17}; dampP = {4'd2, 5'd3}; volP = {4'd2, 5'd9};
    applyReset();
    for (int s = 0; s < 30; s++) runSample("R4 mixed order");
    order = 2'b10;
    for (int s = 0; s < 20; s++) runSample("R4 swapped order");
  endtask

  task automatic testMantissa();
    osc1 = 8'sd1; osc2 = 8'sd0; order = 2'b00;
    cutP = {4'd15, 5'd0}; dampP = {4'd15, 5'd0}; volP = {4'd0, 5'd0};
    applyReset();
    runSample("R3 mantissa zero");
    check("R3 mantissa zero full gain", int'(filtOut), 256);
    volP = {4'd0, 5'd31};
    applyReset();
    runSample("R3 mantissa 31");
    check("R3 mantissa 31 first sample half", int'(filtOut), 128);
    for (int s = 1; s < 32; s++) runSample("R3 mantissa 31 run");
    check("R3 mantissa 31 sum over 32", int'(filtOut), 4224);
  endtask

  task automatic testSaturation();
    osc1 = 8'sd127; osc2 = 8'sd0; order = 2'b00;
    cutP = {4'd15, 5'd0}; dampP = {4'd15, 5'd0}; volP = {4'd0, 5'd0};
    applyReset();
    runSample("R5 positive approach");
    check("R5 first positive", int'(filtOut), 32512);
    for (int s = 0; s < 3; s++) runSample("R5 positive rail");
    check("R5 clamp high", int'(filtOut), 32767);
    osc1 = -8'sd128;
    applyReset();
    for (int s = 0; s < 4; s++) runSample("R5 negative rail");
    check("R5 clamp low", int'(filtOut), -32768);
  endtask

  task automatic testDampAndVolume();
    osc1 = 8'sd100; osc2 = 8'sd0; order = 2'b01;
    cutP = {4'd0, 5'd0}; dampP = {4'd0, 5'd0}; volP = {4'd0, 5'd0};
    applyReset();
    for (int s = 0; s < 8; s++) runSample("R6 full damping");
    check("R6 band cleared keeps output zero", int'(filtOut), 0);
    order = 2'b00; cutP = {4'd15, 5'd0}; dampP = {4'd15, 5'd0}; volP = {4'd15, 5'd0};
    applyReset();
    for (int s = 0; s < 8; s++) runSample("R7 volume off");
    check("R7 input has no effect", int'(filtOut), 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    testReset();
    testSecondOrder();
    testMixedOrder();
    testMantissa();
    testSaturation();
    testDampAndVolume();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule